// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is the external memory port of an 8-bit controller core. It turns each core request (a program fetch, a data read or a data write) into one bus cycle. The low address byte and the data byte share a single 8-bit port, and a second 8-bit port carries the high address byte. An address-latch pulse lets an external latch hold the low byte while the shared port turns around for data. Fetches use a program strobe, data reads a read strobe and data writes a write strobe.

The core holds `req` with its attributes steady until it sees a one-cycle `done` pulse; read data is valid together with that pulse. A fetch is served internally when it targets an address at or below `INT_TOP`, unless the external-access pin was low while reset was held. In that case every later fetch goes out on the bus. Internal fetches are still echoed on the ports, but no strobe fires and the shared port is forced to zero after the address phase. With `bus_en` low the ports act as general-purpose outputs: cycles still run and complete, but the pins are left untouched.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is held and right after it, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `done` is 0, and with `bus_en`=1 `p0_oe` is 0.
- R2: A request is accepted on a clock edge where the block is idle, `req`=1 and `done`=0. `ale` is then high for `T_ALE` clocks, and the active strobe is low for `T_STRB` clocks. `done` rises `T_ALE+T_SETUP+T_STRB+T_HOLD` edges after acceptance.
- R3: The low address byte is driven on `p0_out` with `p0_oe`=1 while `ale` is high, and it is held unchanged in the first clock after `ale` falls.
- R4: For a write, `wdata` is driven on `p0_out` from clock 2 of the setup phase through the hold phase after `wr_n` rises. That is `T_SETUP-1+T_STRB+T_HOLD` clocks, with `p0_oe`=1.
- R5: For an external read or fetch, `rdata` is the `p0_in` value present in the last clock of the strobe-low window, and it is presented with `done`.
- R6: `req_kind` encoding: 2'b00 fetch, 2'b01 read, 2'b10 write. A fetch pulses only `psen_n`, a read only `rd_n` and a write only `wr_n`. At most one strobe is low at any time.
- R7: `ptr_mode`=0 (or any fetch) takes the address from `addr16`. `ptr_mode`=1 on a data access puts `addr8` on the low byte and `page` on `p2_out`. `p2_out` stays constant for the whole cycle.
- R8: A fetch with `addr16` <= `INT_TOP` is internal, unless external fetches were forced at reset. For an internal fetch no strobe falls, and `p0_out` is 0 with `p0_oe`=1 after the address phase. The fetch returns `rdata`=0 with `done_ext`=0.
- R9: A fetch with `addr16` > `INT_TOP` pulses `psen_n`, shows `addr16[15:8]` on `p2_out`, and returns `done_ext`=1.
- R10: If `ea_n` is 0 while reset is held, every fetch after reset is external, including low addresses.
- R11: With `bus_en`=0, `p0_out` and `p2_out` follow `gpio_p0` and `gpio_p2`, and `ale` and all strobes stay inactive. A cycle still completes with normal timing. An external access then returns `rdata`=8'hFF.
- R12: `done` is high for exactly one clock. A `req` still high at the edge that ends the `done` cycle does not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_n | input | 1 | External-access pin, sampled while reset is held |
| bus_en | input | 1 | 1: ports form the memory bus; 0: general-purpose outputs |
| gpio_p0 | input | 8 | Low port value in general-purpose mode |
| gpio_p2 | input | 8 | High port value in general-purpose mode |
| req | input | 1 | Access request, held until `done` |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write |
| ptr_mode | input | 1 | Data access address: 0 16-bit, 1 8-bit plus page |
| addr16 | input | 16 | Program counter or 16-bit data pointer |
| addr8 | input | 8 | 8-bit data pointer |
| page | input | 8 | Page register for 8-bit pointer accesses |
| wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_ext | output | 1 | Completed access went external |
| rdata | output | 8 | Read or fetch data, valid with `done` |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Shared address-low/data port output |
| p0_oe | output | 1 | Shared port output enable |
| p0_in | input | 8 | Shared port input |
| p2_out | output | 8 | High address port output |

## Verification
The completion pulse and a still-asserted request coincide on the clock edge that ends the `done` cycle. A careless idle check would start a second cycle there. The bench keeps `req` high across that edge and then watches several clocks, expecting `ale` low and no further `done`.

The read capture and the read strobe's release also fall on one edge. The bench offers the read byte only in the final strobe-low clock and a different byte elsewhere. A capture on any other edge therefore returns the wrong value.

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
  parameter int T_ALE = 2,
  parameter int T_SETUP = 2,
  parameter int T_STRB = 3,
  parameter int T_HOLD = 1,
  parameter logic [15:0] INT_TOP = 16'h0FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ea_n,
  input  logic        bus_en,
  input  logic [7:0]  gpio_p0,
  input  logic [7:0]  gpio_p2,
  input  logic        req,
  input  logic [1:0]  req_kind,
  input  logic        ptr_mode,
  input  logic [15:0] addr16,
  input  logic [7:0]  addr8,
  input  logic [7:0]  page,
  input  logic [7:0]  wdata,
  output logic        done,
  output logic        done_ext,
  output logic [7:0]  rdata,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  input  logic [7:0]  p0_in,
  output logic [7:0]  p2_out
);
  localparam int M1 = (T_ALE > T_SETUP) ? T_ALE : T_SETUP;
  localparam int M2 = (T_STRB > T_HOLD) ? T_STRB : T_HOLD;
  localparam int T_MAX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(T_MAX + 1);
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LATCH, S_STRB, S_HOLD} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] kind_q;
  logic [7:0] lo_q, hi_q, wd_q;
  logic int_q, bus_q, force_ext;

  wire last  = (cnt == '0);
  wire busy  = (st != S_IDLE);
  wire start = !busy && req && !done;
  wire ptr8  = ptr_mode && (req_kind != K_FETCH);
  wire is_int = (req_kind == K_FETCH) && !force_ext && (addr16 <= INT_TOP);

  always_ff @(posedge clk)
    if (!rst_n) force_ext <= !ea_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      kind_q <= K_FETCH;
      lo_q <= '0;
      hi_q <= '0;
      wd_q <= '0;
      int_q <= 1'b0;
      bus_q <= 1'b0;
      done <= 1'b0;
      done_ext <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          kind_q <= req_kind;
          lo_q <= ptr8 ? addr8 : addr16[7:0];
          hi_q <= ptr8 ? page : addr16[15:8];
          wd_q <= wdata;
          int_q <= is_int;
          bus_q <= bus_en;
          st <= S_ADDR;
          cnt <= CW'(T_ALE - 1);
        end
        S_ADDR: if (last) begin
          st <= S_LATCH;
          cnt <= CW'(T_SETUP - 1);
        end else cnt <= cnt - 1'b1;
        S_LATCH: if (last) begin
          st <= S_STRB;
          cnt <= CW'(T_STRB - 1);
        end else cnt <= cnt - 1'b1;
        S_STRB: if (last) begin
          rdata <= int_q ? 8'h00 : !bus_q ? 8'hFF : (kind_q == K_WRITE) ? 8'h00 : p0_in;
          st <= S_HOLD;
          cnt <= CW'(T_HOLD - 1);
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (last) begin
          st <= S_IDLE;
          done <= 1'b1;
          done_ext <= !int_q;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire bm       = busy ? bus_q : bus_en;
  wire addr_ph  = (st == S_ADDR) || (st == S_LATCH && cnt == CW'(T_SETUP - 1));
  wire is_wr    = (kind_q == K_WRITE);
  wire is_fetch = (kind_q == K_FETCH);
  wire strb     = bus_q && !int_q && (st == S_STRB);

  assign ale    = bus_q && (st == S_ADDR);
  assign psen_n = !(strb && is_fetch);
  assign wr_n   = !(strb && is_wr);
  assign rd_n   = !(strb && !is_fetch && !is_wr);
  assign p0_oe  = !bm ? 1'b1 : busy && (addr_ph || is_wr || int_q);
  assign p0_out = !bm ? gpio_p0 : !busy ? 8'h00 : addr_ph ? lo_q :
                  int_q ? 8'h00 : is_wr ? wd_q : 8'h00;
  assign p2_out = !bm ? gpio_p2 : hi_q;

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!psen_n, !rd_n, !wr_n}));

  a_r3_addr_at_ale_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (p0_oe && $stable(p0_out)));

  a_r4_wr_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (p0_oe && $stable(p0_out)));

  a_r4_wr_data_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (p0_oe && $stable(p0_out)));

  a_r7_high_port_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_q && $past(busy)) |-> $stable(p2_out));

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/xmem_bus_ctrl_bench.sv
module xmem_bus_ctrl_bench;
  localparam int TA = 2, TS = 2, TR = 3, TH = 1;
  localparam int CYC = TA + TS + TR + TH + 1;

  logic clk = 0, rst_n = 0, ea_n = 1, bus_en = 1, req = 0, ptr_mode = 0;
  logic [7:0] gpio_p0 = 8'h00, gpio_p2 = 8'h00, addr8 = 0, page = 0, wdata = 0, p0_in = 8'hA5;
  logic [1:0] req_kind = 0;
  logic [15:0] addr16 = 0;
  logic done, done_ext, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0] rdata, p0_out, p2_out;

  xmem_bus_ctrl #(.T_ALE(TA), .T_SETUP(TS), .T_STRB(TR), .T_HOLD(TH), .INT_TOP(16'h0FFF))
  u_xmem_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .ea_n(ea_n), .bus_en(bus_en), .gpio_p0(gpio_p0),
    .gpio_p2(gpio_p2), .req(req), .req_kind(req_kind), .ptr_mode(ptr_mode),
    .addr16(addr16), .addr8(addr8), .page(page), .wdata(wdata), .done(done),
    .done_ext(done_ext), .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int m_cyc, m_ale, m_psen, m_rd, m_wr, m_zero, m_wd, m_p2bad, m_gpbad;
  logic [7:0] m_lo, m_p2, m_rdata;
  logic m_ext;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic ea);
    @(negedge clk);
    rst_n = 0; ea_n = ea; req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic xfer(input logic [1:0] k, input logic pm, input logic [15:0] a16,
                      input logic [7:0] a8, input logic [7:0] pg, input logic [7:0] wd,
                      input logic [7:0] rv, input bit hold_req);
    logic prev_ale = 0;
    int sc = 0;
    m_cyc = 0; m_ale = 0; m_psen = 0; m_rd = 0; m_wr = 0; m_zero = 0; m_wd = 0;
    m_p2bad = 0; m_gpbad = 0; m_lo = 8'hXX; m_rdata = 8'hXX; m_ext = 1'bx;
    @(negedge clk);
    req = 1; req_kind = k; ptr_mode = pm; addr16 = a16; addr8 = a8; page = pg; wdata = wd;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      m_cyc++;
      if (i == 0) m_p2 = p2_out;
      else if (p2_out !== m_p2) m_p2bad++;
      if (ale) m_ale++;
      if (!psen_n) m_psen++;
      if (!rd_n) m_rd++;
      if (!wr_n) m_wr++;
      if (!psen_n || !rd_n) sc++;
      p0_in = (sc == TR && (!psen_n || !rd_n)) ? rv : 8'h5C;
      if (prev_ale && !ale) m_lo = p0_out;
      if (!ale && !done && p0_oe && p0_out == 8'h00) m_zero++;
      if (!ale && !done && p0_oe && p0_out == wd) m_wd++;
      if (p0_out !== gpio_p0 || p2_out !== gpio_p2) m_gpbad++;
      prev_ale = ale;
      if (done) begin
        m_rdata = rdata; m_ext = done_ext;
        break;
      end
    end
    if (hold_req) @(negedge clk);
    req = 0;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    check("R1 idle pins {ale,psen_n,rd_n,wr_n,done,p0_oe}",
          {ale, psen_n, rd_n, wr_n, done, p0_oe}, 6'b011100);
  endtask

  task automatic t_fetch_int;
    xfer(2'b00, 0, 16'h0234, 0, 0, 8'hEE, 8'h77, 0);
    check("R8 internal fetch no strobe", m_psen + m_rd + m_wr, 0);
    check("R8 internal data phase zero clocks", m_zero, TS - 1 + TR + TH);
    check("R8 internal rdata/ext", {m_rdata, m_ext}, {8'h00, 1'b0});
    check("R3 low byte at ale fall", m_lo, 8'h34);
    check("R2 ale high clocks", m_ale, TA);
  endtask

  task automatic t_fetch_ext;
    xfer(2'b00, 0, 16'h8A7C, 0, 0, 8'hEE, 8'h3D, 0);
    check("R9 psen low clocks", m_psen, TR);
    check("R9 high port pc", {m_p2, 8'(m_p2bad)}, {8'h8A, 8'h00});
    check("R9 ext flag", m_ext, 1'b1);
    check("R5 fetch data", m_rdata, 8'h3D);
    check("R3 fetch low byte", m_lo, 8'h7C);
    check("R2 cycle length", m_cyc, CYC);
  endtask

  task automatic t_read16;
    xfer(2'b01, 0, 16'h1234, 8'h99, 8'h66, 8'hEE, 8'hE1, 0);
    check("R5 read data last strobe clock", m_rdata, 8'hE1);
    check("R6 read strobes {psen,rd,wr}", {8'(m_psen), 8'(m_rd), 8'(m_wr)}, {8'd0, 8'(TR), 8'd0});
    check("R7 16-bit addr", {m_p2, m_lo}, 16'h1234);
  endtask

  task automatic t_read8;
    xfer(2'b01, 1, 16'hFFFF, 8'h56, 8'h9B, 8'hEE, 8'h4F, 0);
    check("R7 8-bit addr + page", {m_p2, m_lo}, 16'h9B56);
    check("R7 page held", m_p2bad, 0);
    check("R5 paged read data", m_rdata, 8'h4F);
  endtask

  task automatic t_write;
    xfer(2'b10, 0, 16'h4321, 0, 0, 8'hC8, 8'h00, 0);
    check("R4 write data clocks", m_wd, TS - 1 + TR + TH);
    check("R6 write strobes {psen,rd,wr}", {8'(m_psen), 8'(m_rd), 8'(m_wr)}, {8'd0, 8'd0, 8'(TR)});
    check("R3 write low byte", m_lo, 8'h21);
  endtask

  task automatic t_gpio;
    @(negedge clk);
    bus_en = 0; gpio_p0 = 8'h5A; gpio_p2 = 8'hC3;
    xfer(2'b01, 0, 16'h2345, 0, 0, 8'hEE, 8'h11, 0);
    check("R11 no ale/strobe", m_ale + m_psen + m_rd + m_wr, 0);
    check("R11 ports untouched", m_gpbad, 0);
    check("R11 rdata", m_rdata, 8'hFF);
    check("R11 cycle length", m_cyc, CYC);
    @(negedge clk);
    bus_en = 1; gpio_p0 = 8'h00; gpio_p2 = 8'h00;
  endtask

  task automatic t_req_held;
    int extra = 0;
    xfer(2'b01, 0, 16'h3000, 0, 0, 8'hEE, 8'h22, 1);
    check("R12 done seen", m_rdata, 8'h22);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ale || done) extra++;
    end
    check("R12 no restart after held req", extra, 0);
  endtask

  task automatic t_ea_low;
    do_reset(1'b0);
    xfer(2'b00, 0, 16'h0010, 0, 0, 8'hEE, 8'h6B, 0);
    check("R10 forced external psen", m_psen, TR);
    check("R10 forced ext data/flag", {m_rdata, m_ext}, {8'h6B, 1'b1});
    do_reset(1'b1);
  endtask

  initial begin
    t_reset();
    t_fetch_int();
    t_fetch_ext();
    t_read16();
    t_read8();
    t_write();
    t_gpio();
    t_req_held();
    t_ea_low();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule